// File: doc/BRIEF.md
# Vector Early-Exit Length Truncation Unit

This block watches the per-element outcomes of a vector loop, one element at a time in ascending order, and decides where the loop stops and what the vector length becomes afterwards. A `start` pulse loads the original length and the configuration. After that, each `elem_valid` cycle presents the result of the next element.

The block has two truncation rules. In memory-fault mode it receives a fault flag for each element. A fault on the first element is reported as an ordinary exception. A fault on any later element silently shortens the length so that it ends just before the faulting element. In condition-test mode it receives a 4-bit condition field for each element. It picks one bit of that field and compares the bit with an invert flag. When the comparison fails, the length is truncated, either to exclude or to include the failing element. This rule may shrink the length to zero.

All outputs are registered. For every accepted element there is a writeback enable, and the stop strobe comes with the new length.

Top module: `vl_trunc_unit`

## Requirements
- R1: After reset, `stop`, `wb_en` and `raise_exc` are 0 and `new_vl` is 0.
- R2: In memory-fault mode (`test_mode`=0), a fault on element 0 gives `raise_exc`=1, `stop`=1, `wb_en`=0 and `new_vl` equal to the loaded length.
- R3: In memory-fault mode, a fault on element k≥1 gives `stop`=1, `raise_exc`=0, `wb_en`=0 and `new_vl`=k. This mode never reports a zero length when the loaded length is nonzero.
- R4: In condition-test mode (`test_mode`=1), the tested bit is `elem_cond[bit_sel]`, where bit 0 is less-than, bit 1 greater-than, bit 2 equal and bit 3 summary-overflow. The element fails when the tested bit equals `inv`. A failure asserts `stop`, and a pass never stops the loop early.
- R5: A condition failure with the inclusive flag in effect clear gives `new_vl`=k and `wb_en`=0 for the failing element. When k=0 this gives a length of 0.
- R6: A condition failure with `incl`=1 and `rc`=0 gives `new_vl`=k+1, and `wb_en` for the failing element is 1 unless `cond_only` is set.
- R7: When `rc`=1, `incl` has no effect: truncation follows R5.
- R8: In condition-test mode with `cond_only`=1, `wb_en` stays 0 for every element, while stopping and `new_vl` behave as with `cond_only`=0.
- R9: If no element stops the loop, the last element (index length−1) gives `stop`=1 and `new_vl` equal to the loaded length. Every element of that loop gets `wb_en`=1, except in the case R8 covers.
- R10: After a stop, further `elem_valid` cycles produce no `wb_en`, `stop` or `raise_exc` until the next `start`.
- R11: A `start` with a length of 0 gives `stop`=1 and `new_vl`=0 in the following cycle.
- R12: The outputs for an element appear in the cycle after the clock edge that samples `elem_valid`. `stop`, `wb_en` and `raise_exc` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads the length and configuration and begins a loop |
| vl_in | input | VLW | Original vector length |
| test_mode | input | 1 | 0 = memory-fault rule, 1 = condition-test rule |
| bit_sel | input | 2 | Condition bit selector (0 LT, 1 GT, 2 EQ, 3 SO) |
| inv | input | 1 | Value of the tested bit that counts as a failure |
| incl | input | 1 | Include the failing element in the new length |
| rc | input | 1 | Record form active; forces `incl` off |
| cond_only | input | 1 | Store condition fields only; no result writeback |
| elem_valid | input | 1 | Next element's outcome is present |
| elem_fault | input | 1 | Element would fault (memory-fault mode) |
| elem_cond | input | 4 | Element's condition field (condition-test mode) |
| new_vl | output | VLW | Resulting vector length, valid with `stop` |
| stop | output | 1 | Loop-end strobe |
| wb_en | output | 1 | Writeback enable for the element just judged |
| raise_exc | output | 1 | Element 0 fault must be taken as an exception |

## Verification
Two functions can land in the same cycle. The first is the stop on the last element of the loop, which comes from the length count. The second is the stop caused by a failing test or fault on that same element. Both must resolve to a single strobe, and the failure result must win (k or k+1 rather than the full length). The bench provokes this on purpose by placing failures and faults at index length−1. It also does so at index 0 with a length of 1, where the exception path and the end-of-loop path meet. Each outcome is judged against a model written from the requirements, checking `new_vl`, `wb_en` and `raise_exc` in that one cycle.

// File: rtl/vl_trunc_pkg.sv
package vl_trunc_pkg;
  typedef enum logic {
    MODE_MEMFAULT = 1'b0,
    MODE_CONDTEST = 1'b1
  } trunc_mode_e;

  typedef struct packed {
    trunc_mode_e mode;
    logic [1:0]  sel;
    logic        inv;
    logic        incl_eff;
    logic        cond_only;
  } trunc_cfg_t;
endpackage

// File: rtl/vl_elem_counter.sv
module vl_elem_counter #(
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           step,
  input  logic           active,
  input  logic [VLW-1:0] vl,
  output logic [VLW-1:0] idx,
  output logic           last
);
  logic [VLW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || clear) idx_q <= '0;
    else if (step)    idx_q <= idx_q + 1'b1;
  end

  assign idx  = idx_q;
  assign last = (idx_q + 1'b1) == vl;

  // index stays inside the loop while it runs (R9)
  assert_idx_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    active |-> idx_q < vl);
endmodule

// File: rtl/vl_cond_test.sv
module vl_cond_test (
  input  logic [3:0] cond,
  input  logic [1:0] sel,
  input  logic       inv,
  output logic       fail
);
  logic picked;
  always_comb begin
    picked = cond[sel];
    fail   = (picked == inv);
  end
endmodule

// File: rtl/vl_decide.sv
module vl_decide
  import vl_trunc_pkg::*;
#(
  parameter int VLW = 7
) (
  input  trunc_cfg_t     cfg,
  input  logic [VLW-1:0] idx,
  input  logic [VLW-1:0] vl,
  input  logic           last,
  input  logic           fault,
  input  logic           cond_fail,
  output logic           stop,
  output logic [VLW-1:0] nvl,
  output logic           wb,
  output logic           exc
);
  always_comb begin
    stop = last;
    nvl  = vl;
    wb   = 1'b1;
    exc  = 1'b0;
    if (cfg.mode == MODE_MEMFAULT) begin
      if (fault) begin
        stop = 1'b1;
        wb   = 1'b0;
        if (idx == '0) exc = 1'b1;
        else           nvl = idx;
      end
    end else begin
      wb = !cfg.cond_only;
      if (cond_fail) begin
        stop = 1'b1;
        nvl  = idx + {{(VLW-1){1'b0}}, cfg.incl_eff};
        wb   = cfg.incl_eff && !cfg.cond_only;
      end
    end
  end
endmodule

// File: rtl/vl_trunc_unit.sv
module vl_trunc_unit
  import vl_trunc_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW   = $clog2(MAX_VL + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [VLW-1:0] vl_in,
  input  logic           test_mode,
  input  logic [1:0]     bit_sel,
  input  logic           inv,
  input  logic           incl,
  input  logic           rc,
  input  logic           cond_only,
  input  logic           elem_valid,
  input  logic           elem_fault,
  input  logic [3:0]     elem_cond,
  output logic [VLW-1:0] new_vl,
  output logic           stop,
  output logic           wb_en,
  output logic           raise_exc
);
  trunc_cfg_t     cfg_q;
  logic [VLW-1:0] vl_q;
  logic           active_q;
  logic [VLW-1:0] new_vl_q;
  logic           stop_q, wb_q, exc_q;

  logic [VLW-1:0] idx;
  logic           last, cond_fail, accept;
  logic           d_stop, d_wb, d_exc;
  logic [VLW-1:0] d_nvl;

  assign accept = active_q && elem_valid && !start;

  vl_elem_counter #(.VLW(VLW)) u_ctr (
    .clk(clk), .rst(rst), .clear(start), .step(accept),
    .active(active_q), .vl(vl_q), .idx(idx), .last(last)
  );

  vl_cond_test u_test (
    .cond(elem_cond), .sel(cfg_q.sel), .inv(cfg_q.inv), .fail(cond_fail)
  );

  vl_decide #(.VLW(VLW)) u_dec (
    .cfg(cfg_q), .idx(idx), .vl(vl_q), .last(last), .fault(elem_fault),
    .cond_fail(cond_fail), .stop(d_stop), .nvl(d_nvl), .wb(d_wb), .exc(d_exc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      vl_q     <= '0;
      active_q <= 1'b0;
      new_vl_q <= '0;
      stop_q   <= 1'b0;
      wb_q     <= 1'b0;
      exc_q    <= 1'b0;
    end else begin
      stop_q <= 1'b0;
      wb_q   <= 1'b0;
      exc_q  <= 1'b0;
      if (start) begin
        cfg_q.mode      <= trunc_mode_e'(test_mode);
        cfg_q.sel       <= bit_sel;
        cfg_q.inv       <= inv;
        cfg_q.incl_eff  <= incl && !rc;
        cfg_q.cond_only <= cond_only;
        vl_q            <= vl_in;
        if (vl_in == '0) begin
          active_q <= 1'b0;
          stop_q   <= 1'b1;
          new_vl_q <= '0;
        end else begin
          active_q <= 1'b1;
        end
      end else if (accept) begin
        wb_q  <= d_wb;
        exc_q <= d_exc;
        if (d_stop) begin
          stop_q   <= 1'b1;
          new_vl_q <= d_nvl;
          active_q <= 1'b0;
        end
      end
    end
  end

  assign new_vl    = new_vl_q;
  assign stop      = stop_q;
  assign wb_en     = wb_q;
  assign raise_exc = exc_q;

  // memory-fault rule never reports zero for a nonzero loop (R3)
  assert_mem_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    (stop_q && cfg_q.mode == MODE_MEMFAULT && vl_q != '0) |-> new_vl_q != '0);
  // exception keeps the original length and ends the loop (R2)
  assert_exc_keeps_vl_R2: assert property (@(posedge clk) disable iff (rst)
    exc_q |-> (stop_q && new_vl_q == vl_q));
  // condition-only stores no results (R8)
  assert_no_wb_cond_only_R8: assert property (@(posedge clk) disable iff (rst)
    wb_q |-> !(cfg_q.mode == MODE_CONDTEST && cfg_q.cond_only));
  // truncation never grows the length (R5)
  assert_no_growth_R5: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> new_vl_q <= vl_q);
  // stop is a single-cycle pulse (R12)
  assert_stop_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    stop_q |=> !stop_q || $past(start));
endmodule

// File: tb/vl_trunc_unit_bench.sv
module vl_trunc_unit_bench;
  localparam int MAX_VL = 64;
  localparam int VLW = $clog2(MAX_VL + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, test_mode = 0, inv = 0, incl = 0, rc = 0, cond_only = 0;
  logic [1:0] bit_sel = 0;
  logic [VLW-1:0] vl_in = 0;
  logic elem_valid = 0, elem_fault = 0;
  logic [3:0] elem_cond = 0;
  logic [VLW-1:0] new_vl;
  logic stop, wb_en, raise_exc;

  int n_checks = 0, n_fail = 0;
  logic       flt[32];
  logic [3:0] cnd[32];

  always #10 clk = ~clk;

  vl_trunc_unit #(.MAX_VL(MAX_VL)) u_vl_trunc_unit (
    .clk(clk), .rst(rst), .start(start), .vl_in(vl_in), .test_mode(test_mode),
    .bit_sel(bit_sel), .inv(inv), .incl(incl), .rc(rc), .cond_only(cond_only),
    .elem_valid(elem_valid), .elem_fault(elem_fault), .elem_cond(elem_cond),
    .new_vl(new_vl), .stop(stop), .wb_en(wb_en), .raise_exc(raise_exc));

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one loop: elements presented one per cycle, two extra after the length
  task automatic run_loop(input int vl, input logic md, input logic [1:0] sl,
                          input logic iv, input logic ic, input logic r,
                          input logic co);
    bit act;
    int e_nvl;
    bit e_stop, e_wb, e_exc, fl, ie;
    @(negedge clk);
    start = 1; vl_in = VLW'(vl); test_mode = md; bit_sel = sl; inv = iv;
    incl = ic; rc = r; cond_only = co;
    @(negedge clk);
    start = 0;
    chk("R11 stop after start", int'(stop), vl == 0);
    if (vl == 0) chk("R11 zero length", int'(new_vl), 0);
    act = (vl != 0);
    ie = ic && !r;
    for (int k = 0; k < vl + 2; k++) begin
      elem_valid = 1; elem_fault = flt[k]; elem_cond = cnd[k];
      e_stop = 0; e_wb = 0; e_exc = 0; e_nvl = vl;
      if (act) begin
        if (!md) begin
          if (flt[k]) begin
            e_stop = 1;
            if (k == 0) e_exc = 1; else e_nvl = k;
          end else begin
            e_wb = 1;
            e_stop = (k == vl - 1);
          end
        end else begin
          fl = (cnd[k][sl] == iv);
          if (fl) begin
            e_stop = 1; e_nvl = k + int'(ie); e_wb = ie && !co;
          end else begin
            e_wb = !co; e_stop = (k == vl - 1);
          end
        end
        if (e_stop) act = 0;
      end
      @(negedge clk);
      elem_valid = 0;
      if (k >= vl) begin
        chk("R10 stop ignored", int'(stop), 0);
        chk("R10 wb ignored", int'(wb_en), 0);
      end else begin
        chk(md ? "R4 stop" : "R2 R3 stop", int'(stop), int'(e_stop));
        chk(md ? (co ? "R8 wb" : "R5 R6 R9 wb") : "R3 R9 wb", int'(wb_en), int'(e_wb));
        chk("R2 exc", int'(raise_exc), int'(e_exc));
        if (e_stop)
          chk(md ? (r ? "R7 new_vl" : "R5 R6 new_vl") : "R2 R3 new_vl",
              int'(new_vl), e_nvl);
        if (e_stop && !md && vl != 0) chk("R3 nonzero", int'(new_vl != 0), 1);
      end
    end
    @(negedge clk);
    chk("R12 pulse", int'(stop | wb_en | raise_exc), 0);
  endtask

  task automatic clear_elems(input logic [3:0] c);
    for (int i = 0; i < 32; i++) begin flt[i] = 0; cnd[i] = c; end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 stop", int'(stop), 0);
    chk("R1 wb", int'(wb_en), 0);
    chk("R1 exc", int'(raise_exc), 0);
    chk("R1 new_vl", int'(new_vl), 0);
    // R2: fault on element 0
    clear_elems(4'h0); flt[0] = 1; run_loop(5, 0, 0, 0, 0, 0, 0);
    // R3: fault on element 3 and on the last element
    clear_elems(4'h0); flt[3] = 1; run_loop(8, 0, 0, 0, 0, 0, 0);
    clear_elems(4'h0); flt[7] = 1; run_loop(8, 0, 0, 0, 0, 0, 0);
    // R2 with length 1: exception meets loop end
    clear_elems(4'h0); flt[0] = 1; run_loop(1, 0, 0, 0, 0, 0, 0);
    // R9: no fault, full loop
    clear_elems(4'h0); run_loop(6, 0, 0, 0, 0, 0, 0);
    // R5: EQ bit (2) set on element 0, inv=1 -> zero length
    clear_elems(4'h0); cnd[0] = 4'b0100; run_loop(4, 1, 2, 1, 0, 0, 0);
    // R6: inclusive on element 2
    clear_elems(4'h0); cnd[2] = 4'b0100; run_loop(6, 1, 2, 1, 1, 0, 0);
    // R7: rc forces inclusive off
    clear_elems(4'h0); cnd[2] = 4'b0100; run_loop(6, 1, 2, 1, 1, 1, 0);
    // R8: condition-only, fail at last element
    clear_elems(4'h0); cnd[4] = 4'b0100; run_loop(5, 1, 2, 1, 1, 0, 1);
    // R4: LT bit (0) clear with inv=0 fails at element 3
    clear_elems(4'h1); cnd[3] = 4'h0; run_loop(7, 1, 0, 0, 0, 0, 0);
    // R11: zero length
    clear_elems(4'h0); run_loop(0, 1, 0, 0, 0, 0, 0);
    // random mix
    for (int t = 0; t < 300; t++) begin
      for (int i = 0; i < 32; i++) begin
        flt[i] = ($urandom % 10) == 0;
        cnd[i] = 4'($urandom);
      end
      run_loop($urandom % 20, 1'($urandom), 2'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule